// File: doc/BRIEF.md
# Convolution Layer Pixel Sequencer

This block is the control state machine for one convolution layer. It takes the layer's shape (rows, columns, input and output channel counts), a stride-2 selector and a global-pool enable. A one-cycle start pulse captures all of them. The block then issues a fixed sequence of commands to five neighbouring units: a weight loader, an image prefetcher, a processing element, a post-processor and a write-back unit. A sixth command goes to a global-pool accumulator when pooling is enabled. Every command is a valid/done pair. The sequencer holds a command's valid and payload until the unit returns done, and only then moves on.

Before any compute starts, the block loads the weights and asks the prefetcher for one full image row and one single pixel. It then walks the input grid row by row. At each position it requests one more pixel prefetch. When stride 2 is selected, it drops positions that have an odd row or column. For each position it keeps, it runs the processing element once per input channel. It then works through the output channels, issuing post-process, write-back and, if enabled, a pooling update for each one. The output coordinate is the input coordinate when stride is 1, and half of it when stride is 2. The memory path, the arithmetic and the caches are not part of this block.

Top module: `conv_layer_seq`

## Requirements
- R1: While idle, a start pulse latches every cfg_* input and the block leaves idle. The first command is a weight load, and no other command is issued until wld_done returns.
- R2: After the weight load, the block issues a prefetch with pre_full_row=1 (full row), then a prefetch with pre_full_row=0 (single pixel), then begins the scan.
- R3: The scan visits positions in row-major order: column index fastest, rows 0..cfg_rows-1, columns 0..cfg_cols-1. Each position gets exactly one pixel prefetch (pre_full_row=0) before any other command for that position. This includes positions that are skipped.
- R4: With cfg_stride2=1, a position whose row or column index is odd gets no processing, post-process, write-back or pool command.
- R5: For each processed position, pe_valid is issued once per input channel. The channels go in order pe_ci = 0..cfg_ch_in-1, carrying the input row and column on pe_y/pe_x. All of them finish before the output-channel phase.
- R6: In the output-channel phase, for co = 0..cfg_ch_out-1 in order, a post-process (pp_co=co) is followed by a write-back (wb_co=co). The write-back carries the output coordinate: equal to the input coordinate for stride 1, and the input coordinate halved (rounded down) for stride 2.
- R7: With cfg_gpool=1, each write-back is followed by a pool command for the same channel. gp_set is 1 when the output coordinate is (0,0) and 0 otherwise. With cfg_gpool=0, no pool command is issued.
- R8: At most one command valid is high at a time. A valid and its payload stay stable until the matching done is seen.
- R9: layer_done rises only after the final command of the last position completes, and the block is idle at that point. layer_done clears on the next accepted start. A start pulse while the block is busy is ignored.
- R10: After reset the block is idle, layer_done is 0 and every command valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| cfg_rows | input | DIM_W | Input rows (at least 1) |
| cfg_cols | input | DIM_W | Input columns (at least 1) |
| cfg_ch_in | input | CH_W | Input channel count (at least 1) |
| cfg_ch_out | input | CH_W | Output channel count (at least 1) |
| cfg_stride2 | input | 1 | 1 selects stride 2 |
| cfg_gpool | input | 1 | 1 enables global-pool commands |
| idle | output | 1 | Block is waiting for start |
| layer_done | output | 1 | Layer finished; cleared by next start |
| wld_valid | output | 1 | Weight load request |
| wld_done | input | 1 | Weight load complete |
| pre_valid | output | 1 | Prefetch request |
| pre_full_row | output | 1 | 1 = whole row, 0 = one pixel |
| pre_done | input | 1 | Prefetch complete |
| pe_valid | output | 1 | Processing-element request |
| pe_y | output | DIM_W | Input row |
| pe_x | output | DIM_W | Input column |
| pe_ci | output | CH_W | Input channel |
| pe_done | input | 1 | Processing complete |
| pp_valid | output | 1 | Post-process request |
| pp_co | output | CH_W | Output channel |
| pp_done | input | 1 | Post-process complete |
| wb_valid | output | 1 | Write-back request |
| wb_y | output | DIM_W | Output row |
| wb_x | output | DIM_W | Output column |
| wb_co | output | CH_W | Output channel |
| wb_done | input | 1 | Write-back complete |
| gp_valid | output | 1 | Pool update request |
| gp_set | output | 1 | 1 = initialise, 0 = accumulate |
| gp_co | output | CH_W | Output channel |
| gp_done | input | 1 | Pool update complete |

## Verification
A wrong state or a stale counter shows up at the ports on the very next command, because every command carries its coordinates or channel and the commands form one ordered stream. A misplaced prefetch, a lost skip, or a wrong input or output channel becomes a mismatch against the expected stream within one handshake. A wrong halving of the coordinate shows up at the first write-back of an odd-free position. A done flag raised too early leaves expected commands unseen at the moment layer_done rises.

// File: rtl/cls_pkg.sv
package cls_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WLOAD,
      ST_PRE_ROW,
      ST_PRE_PIX0,
      ST_PIX_PRE,
      ST_PE,
      ST_PP,
      ST_WB,
      ST_GP,
      ST_NEXT
   } seq_state_e;

endpackage

// File: rtl/cls_scan_ctr.sv
module cls_scan_ctr #(
   parameter int DIM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [DIM_W-1:0] rows,
   input  logic [DIM_W-1:0] cols,
   output logic [DIM_W-1:0] row_idx,
   output logic [DIM_W-1:0] col_idx,
   output logic             at_end
);
   localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

   logic row_end;
   assign row_end = (col_idx == cols - ONE);
   assign at_end  = row_end && (row_idx == rows - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_idx <= '0;
         col_idx <= '0;
      end else if (clear) begin
         row_idx <= '0;
         col_idx <= '0;
      end else if (step) begin
         if (row_end) begin
            col_idx <= '0;
            row_idx <= row_idx + ONE;
         end else begin
            col_idx <= col_idx + ONE;
         end
      end
   end
endmodule

// File: rtl/cls_chan_ctr.sv
module cls_chan_ctr #(
   parameter int CH_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            step,
   input  logic [CH_W-1:0] count,
   output logic [CH_W-1:0] idx,
   output logic            at_last
);
   localparam logic [CH_W-1:0] ONE = CH_W'(1);

   assign at_last = (idx == count - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (clear)  idx <= '0;
      else if (step)   idx <= idx + ONE;
   end
endmodule

// File: rtl/cls_out_coord.sv
module cls_out_coord #(
   parameter int DIM_W           = 8,
   parameter bit SUPPORT_STRIDE2 = 1'b1
) (
   input  logic             stride2,
   input  logic [DIM_W-1:0] in_y,
   input  logic [DIM_W-1:0] in_x,
   output logic [DIM_W-1:0] out_y,
   output logic [DIM_W-1:0] out_x,
   output logic             skip,
   output logic             origin
);
   generate
      if (SUPPORT_STRIDE2) begin : g_s2
         assign out_y  = stride2 ? (in_y >> 1) : in_y;
         assign out_x  = stride2 ? (in_x >> 1) : in_x;
         assign skip   = stride2 && (in_y[0] || in_x[0]);
      end else begin : g_s1
         logic unused_s;
         assign unused_s = stride2;
         assign out_y    = in_y;
         assign out_x    = in_x;
         assign skip     = 1'b0;
      end
   endgenerate

   assign origin = (out_y == '0) && (out_x == '0);
endmodule

// File: rtl/conv_layer_seq.sv
module conv_layer_seq
   import cls_pkg::*;
#(
   parameter int DIM_W           = 8,
   parameter int CH_W            = 8,
   parameter bit SUPPORT_STRIDE2 = 1'b1,
   parameter bit HAS_GPOOL       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIM_W-1:0] cfg_rows,
   input  logic [DIM_W-1:0] cfg_cols,
   input  logic [CH_W-1:0]  cfg_ch_in,
   input  logic [CH_W-1:0]  cfg_ch_out,
   input  logic             cfg_stride2,
   input  logic             cfg_gpool,
   output logic             idle,
   output logic             layer_done,
   output logic             wld_valid,
   input  logic             wld_done,
   output logic             pre_valid,
   output logic             pre_full_row,
   input  logic             pre_done,
   output logic             pe_valid,
   output logic [DIM_W-1:0] pe_y,
   output logic [DIM_W-1:0] pe_x,
   output logic [CH_W-1:0]  pe_ci,
   input  logic             pe_done,
   output logic             pp_valid,
   output logic [CH_W-1:0]  pp_co,
   input  logic             pp_done,
   output logic             wb_valid,
   output logic [DIM_W-1:0] wb_y,
   output logic [DIM_W-1:0] wb_x,
   output logic [CH_W-1:0]  wb_co,
   input  logic             wb_done,
   output logic             gp_valid,
   output logic             gp_set,
   output logic [CH_W-1:0]  gp_co,
   input  logic             gp_done
);
   localparam int MIN_W = 2;
   localparam int MAX_W = 16;

   generate
      if (DIM_W < MIN_W || DIM_W > MAX_W) begin : g_bad_dim
         $error("conv_layer_seq: DIM_W out of range");
      end
      if (CH_W < 1 || CH_W > MAX_W) begin : g_bad_ch
         $error("conv_layer_seq: CH_W out of range");
      end
   endgenerate

   seq_state_e st_q, st_d;

   logic [DIM_W-1:0] rows_q, cols_q;
   logic [CH_W-1:0]  cin_q, cout_q;
   logic             s2_q, gp_q;
   logic             done_q;

   logic             accept;
   logic             scan_clr, scan_step, scan_last;
   logic [DIM_W-1:0] cur_y, cur_x, out_y, out_x;
   logic             ci_clr, ci_step, ci_last;
   logic             co_clr, co_step, co_last;
   logic [CH_W-1:0]  ci_idx, co_idx;
   logic             skip, origin;
   logic             gp_on;

   assign accept = (st_q == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rows_q <= '0;
         cols_q <= '0;
         cin_q  <= '0;
         cout_q <= '0;
         s2_q   <= 1'b0;
         gp_q   <= 1'b0;
      end else if (accept) begin
         rows_q <= cfg_rows;
         cols_q <= cfg_cols;
         cin_q  <= cfg_ch_in;
         cout_q <= cfg_ch_out;
         s2_q   <= cfg_stride2;
         gp_q   <= cfg_gpool;
      end
   end

   cls_scan_ctr #(.DIM_W(DIM_W)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (scan_clr),
      .step    (scan_step),
      .rows    (rows_q),
      .cols    (cols_q),
      .row_idx (cur_y),
      .col_idx (cur_x),
      .at_end  (scan_last)
   );

   cls_chan_ctr #(.CH_W(CH_W)) u_ci (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ci_clr),
      .step    (ci_step),
      .count   (cin_q),
      .idx     (ci_idx),
      .at_last (ci_last)
   );

   cls_chan_ctr #(.CH_W(CH_W)) u_co (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (co_clr),
      .step    (co_step),
      .count   (cout_q),
      .idx     (co_idx),
      .at_last (co_last)
   );

   cls_out_coord #(.DIM_W(DIM_W), .SUPPORT_STRIDE2(SUPPORT_STRIDE2)) u_coord (
      .stride2 (s2_q),
      .in_y    (cur_y),
      .in_x    (cur_x),
      .out_y   (out_y),
      .out_x   (out_x),
      .skip    (skip),
      .origin  (origin)
   );

   generate
      if (HAS_GPOOL) begin : g_pool
         assign gp_on    = gp_q;
         assign gp_valid = (st_q == ST_GP);
      end else begin : g_nopool
         logic unused_p;
         assign unused_p = gp_q ^ gp_done;
         assign gp_on    = 1'b0;
         assign gp_valid = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d      = st_q;
      scan_clr  = 1'b0;
      scan_step = 1'b0;
      ci_clr    = 1'b0;
      ci_step   = 1'b0;
      co_clr    = 1'b0;
      co_step   = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_d     = ST_WLOAD;
               scan_clr = 1'b1;
            end
         end
         ST_WLOAD:    if (wld_done) st_d = ST_PRE_ROW;
         ST_PRE_ROW:  if (pre_done) st_d = ST_PRE_PIX0;
         ST_PRE_PIX0: if (pre_done) st_d = ST_PIX_PRE;
         ST_PIX_PRE: begin
            if (pre_done) begin
               if (skip) begin
                  st_d = ST_NEXT;
               end else begin
                  st_d   = ST_PE;
                  ci_clr = 1'b1;
               end
            end
         end
         ST_PE: begin
            if (pe_done) begin
               if (ci_last) begin
                  st_d   = ST_PP;
                  co_clr = 1'b1;
               end else begin
                  ci_step = 1'b1;
               end
            end
         end
         ST_PP: if (pp_done) st_d = ST_WB;
         ST_WB: begin
            if (wb_done) begin
               if (gp_on) begin
                  st_d = ST_GP;
               end else if (co_last) begin
                  st_d = ST_NEXT;
               end else begin
                  st_d    = ST_PP;
                  co_step = 1'b1;
               end
            end
         end
         ST_GP: begin
            if (gp_done) begin
               if (co_last) begin
                  st_d = ST_NEXT;
               end else begin
                  st_d    = ST_PP;
                  co_step = 1'b1;
               end
            end
         end
         ST_NEXT: begin
            if (scan_last) begin
               st_d = ST_IDLE;
            end else begin
               st_d      = ST_PIX_PRE;
               scan_step = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              done_q <= 1'b0;
      else if (accept)                         done_q <= 1'b0;
      else if (st_q == ST_NEXT && scan_last)   done_q <= 1'b1;
   end

   assign idle         = (st_q == ST_IDLE);
   assign layer_done   = done_q;
   assign wld_valid    = (st_q == ST_WLOAD);
   assign pre_valid    = (st_q == ST_PRE_ROW) || (st_q == ST_PRE_PIX0) ||
                         (st_q == ST_PIX_PRE);
   assign pre_full_row = (st_q == ST_PRE_ROW);
   assign pe_valid     = (st_q == ST_PE);
   assign pe_y         = cur_y;
   assign pe_x         = cur_x;
   assign pe_ci        = ci_idx;
   assign pp_valid     = (st_q == ST_PP);
   assign pp_co        = co_idx;
   assign wb_valid     = (st_q == ST_WB);
   assign wb_y         = out_y;
   assign wb_x         = out_x;
   assign wb_co        = co_idx;
   assign gp_set       = origin;
   assign gp_co        = co_idx;
endmodule

// File: rtl/cls_seq_chk.sv
module cls_seq_chk #(
   parameter int DIM_W = 8,
   parameter int CH_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             idle,
   input logic             layer_done,
   input logic             cfg_stride2,
   input logic             cfg_gpool,
   input logic             wld_valid,
   input logic             pre_valid,
   input logic             pe_valid,
   input logic             pe_done,
   input logic [DIM_W-1:0] pe_y,
   input logic [DIM_W-1:0] pe_x,
   input logic [CH_W-1:0]  pe_ci,
   input logic             pp_valid,
   input logic             wb_valid,
   input logic             wb_done,
   input logic [DIM_W-1:0] wb_y,
   input logic [DIM_W-1:0] wb_x,
   input logic [CH_W-1:0]  wb_co,
   input logic             gp_valid
);
   logic s2_seen, gp_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_seen <= 1'b0;
         gp_seen <= 1'b0;
      end else if (start && idle) begin
         s2_seen <= cfg_stride2;
         gp_seen <= cfg_gpool;
      end
   end

   p_first_wload_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idle) |=> wld_valid);

   p_no_odd_pe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_valid && s2_seen) |-> (!pe_y[0] && !pe_x[0]));

   p_no_pool_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gp_seen && !idle) |-> !gp_valid);

   p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wld_valid, pre_valid, pe_valid, pp_valid, wb_valid, gp_valid}));

   p_pe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_valid && !pe_done) |=>
         (pe_valid && $stable(pe_y) && $stable(pe_x) && $stable(pe_ci)));

   p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_done) |=>
         (wb_valid && $stable(wb_y) && $stable(wb_x) && $stable(wb_co)));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      layer_done |-> idle);
endmodule

bind conv_layer_seq cls_seq_chk #(.DIM_W(DIM_W), .CH_W(CH_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .idle        (idle),
   .layer_done  (layer_done),
   .cfg_stride2 (cfg_stride2),
   .cfg_gpool   (cfg_gpool),
   .wld_valid   (wld_valid),
   .pre_valid   (pre_valid),
   .pe_valid    (pe_valid),
   .pe_done     (pe_done),
   .pe_y        (pe_y),
   .pe_x        (pe_x),
   .pe_ci       (pe_ci),
   .pp_valid    (pp_valid),
   .wb_valid    (wb_valid),
   .wb_done     (wb_done),
   .wb_y        (wb_y),
   .wb_x        (wb_x),
   .wb_co       (wb_co),
   .gp_valid    (gp_valid)
);

// File: tb/conv_layer_seq_bench.sv
`timescale 1ns/1ps
module conv_layer_seq_bench;
   localparam int DW = 8;
   localparam int CW = 8;

   typedef struct packed {
      logic [2:0] kind;
      logic [7:0] a;
      logic [7:0] b;
      logic [7:0] c;
      logic       f;
   } ev_t;

   localparam logic [2:0] K_WLD = 3'd0, K_ROW = 3'd1, K_PIX = 3'd2, K_PE = 3'd3,
                          K_PP = 3'd4, K_WB = 3'd5, K_GP = 3'd6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] cfg_rows = '0, cfg_cols = '0;
   logic [CW-1:0] cfg_ch_in = '0, cfg_ch_out = '0;
   logic cfg_stride2 = 1'b0, cfg_gpool = 1'b0;
   logic idle, layer_done;
   logic wld_valid, pre_valid, pre_full_row, pe_valid, pp_valid, wb_valid, gp_valid, gp_set;
   logic wld_done = 0, pre_done = 0, pe_done = 0, pp_done = 0, wb_done = 0, gp_done = 0;
   logic [DW-1:0] pe_y, pe_x, wb_y, wb_x;
   logic [CW-1:0] pe_ci, pp_co, wb_co, gp_co;

   int n_tests = 0;
   int n_fail  = 0;
   int odd_pe  = 0;
   int overlap = 0;
   int dly     = 0;
   bit cur_s2  = 0;
   ev_t exp_q[$];

   always #2.5 clk = ~clk;

   conv_layer_seq u_conv_layer_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_ch_in(cfg_ch_in),
      .cfg_ch_out(cfg_ch_out), .cfg_stride2(cfg_stride2), .cfg_gpool(cfg_gpool),
      .idle(idle), .layer_done(layer_done),
      .wld_valid(wld_valid), .wld_done(wld_done),
      .pre_valid(pre_valid), .pre_full_row(pre_full_row), .pre_done(pre_done),
      .pe_valid(pe_valid), .pe_y(pe_y), .pe_x(pe_x), .pe_ci(pe_ci), .pe_done(pe_done),
      .pp_valid(pp_valid), .pp_co(pp_co), .pp_done(pp_done),
      .wb_valid(wb_valid), .wb_y(wb_y), .wb_x(wb_x), .wb_co(wb_co), .wb_done(wb_done),
      .gp_valid(gp_valid), .gp_set(gp_set), .gp_co(gp_co), .gp_done(gp_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic string req_of(input logic [2:0] k);
      case (k)
         K_WLD:       return "R1";
         K_ROW:       return "R2";
         K_PIX:       return "R3";
         K_PE:        return "R5";
         K_PP, K_WB:  return "R6";
         default:     return "R7";
      endcase
   endfunction

   // driver side of the scoreboard: expected command stream for one layer
   task automatic push_layer(input int h, input int w, input int ci, input int co,
                             input bit s2, input bit gp);
      exp_q.push_back('{K_WLD, 8'd0, 8'd0, 8'd0, 1'b0});
      exp_q.push_back('{K_ROW, 8'd0, 8'd0, 8'd0, 1'b0});
      exp_q.push_back('{K_PIX, 8'd0, 8'd0, 8'd0, 1'b0});
      for (int y = 0; y < h; y++) begin
         for (int x = 0; x < w; x++) begin
            int oy, ox;
            exp_q.push_back('{K_PIX, 8'd0, 8'd0, 8'd0, 1'b0});
            if (s2 && ((y % 2) == 1 || (x % 2) == 1)) continue;
            for (int c = 0; c < ci; c++)
               exp_q.push_back('{K_PE, 8'(y), 8'(x), 8'(c), 1'b0});
            oy = s2 ? y / 2 : y;
            ox = s2 ? x / 2 : x;
            for (int c = 0; c < co; c++) begin
               exp_q.push_back('{K_PP, 8'd0, 8'd0, 8'(c), 1'b0});
               exp_q.push_back('{K_WB, 8'(oy), 8'(ox), 8'(c), 1'b0});
               if (gp)
                  exp_q.push_back('{K_GP, 8'd0, 8'd0, 8'(c), (oy == 0 && ox == 0)});
            end
         end
      end
   endtask

   // responder plus monitor: grants done after a random delay, logs the command
   always @(negedge clk) begin
      ev_t got, want;
      int nv;
      nv = int'(wld_valid) + int'(pre_valid) + int'(pe_valid) + int'(pp_valid) +
           int'(wb_valid) + int'(gp_valid);
      if (nv > 1) overlap++;
      if (wld_done | pre_done | pe_done | pp_done | wb_done | gp_done) begin
         {wld_done, pre_done, pe_done, pp_done, wb_done, gp_done} = '0;
      end else if (nv != 0 && rst_n) begin
         if (dly > 0) begin
            dly--;
         end else begin
            got = '0;
            if (wld_valid) begin got.kind = K_WLD; wld_done = 1; end
            if (pre_valid) begin got.kind = pre_full_row ? K_ROW : K_PIX; pre_done = 1; end
            if (pe_valid) begin
               got = '{K_PE, pe_y, pe_x, pe_ci, 1'b0}; pe_done = 1;
               if (cur_s2 && (pe_y[0] || pe_x[0])) odd_pe++;
            end
            if (pp_valid) begin got = '{K_PP, 8'd0, 8'd0, pp_co, 1'b0}; pp_done = 1; end
            if (wb_valid) begin got = '{K_WB, wb_y, wb_x, wb_co, 1'b0}; wb_done = 1; end
            if (gp_valid) begin got = '{K_GP, 8'd0, 8'd0, gp_co, gp_set}; gp_done = 1; end
            if (exp_q.size() == 0) begin
               check(0, req_of(got.kind), "unexpected command", got, 0);
            end else begin
               want = exp_q.pop_front();
               check(got == want, req_of(want.kind), "command stream", got, want);
            end
            dly = $urandom_range(0, 2);
         end
      end
   end

   task automatic run_layer(input int h, input int w, input int ci, input int co,
                            input bit s2, input bit gp, input bit poke);
      int cyc;
      push_layer(h, w, ci, co, s2, gp);
      odd_pe = 0;
      cur_s2 = s2;
      @(negedge clk);
      cfg_rows = DW'(h); cfg_cols = DW'(w); cfg_ch_in = CW'(ci); cfg_ch_out = CW'(co);
      cfg_stride2 = s2; cfg_gpool = gp; start = 1;
      @(negedge clk);
      start = 0;
      check(!idle && !layer_done, "R9", "busy and done cleared after start",
            {idle, layer_done}, 2'b00);
      cyc = 0;
      while (!layer_done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 15) begin
            cfg_rows = 8'd9; cfg_ch_out = 8'd5; start = 1;
         end else if (poke && cyc == 16) begin
            start = 0;
            cfg_rows = DW'(h); cfg_ch_out = CW'(co);
         end
      end
      check(layer_done && idle, "R9", "layer_done and idle at end", {layer_done, idle}, 2'b11);
      check(exp_q.size() == 0, "R9", "expected commands left when done", exp_q.size(), 0);
      if (s2) check(odd_pe == 0, "R4", "odd-position PE commands", odd_pe, 0);
      check(overlap == 0, "R8", "overlapping valids", overlap, 0);
      exp_q.delete();
   endtask

   initial begin
      #(5.0 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(idle && !layer_done, "R10", "idle/done after reset", {idle, layer_done}, 2'b10);
      check({wld_valid, pre_valid, pe_valid, pp_valid, wb_valid, gp_valid} == '0,
            "R10", "valids after reset",
            {wld_valid, pre_valid, pe_valid, pp_valid, wb_valid, gp_valid}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // stride 1, pooling, start pulse during busy (R9)
      run_layer(3, 4, 2, 2, 1'b0, 1'b1, 1'b1);
      // stride 2 odd-size grid with pooling (R4, R6, R7)
      run_layer(5, 5, 1, 2, 1'b1, 1'b1, 1'b0);
      // stride 2 without pooling (R7 off)
      run_layer(4, 3, 3, 1, 1'b1, 1'b0, 1'b0);
      // single pixel, single channel corner case
      run_layer(1, 1, 1, 1, 1'b0, 1'b1, 1'b0);
      // R1: block stays idle without start
      repeat (5) @(negedge clk);
      check(idle && !wld_valid, "R1", "no activity without start", {idle, wld_valid}, 2'b10);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule